// File: doc/BRIEF.md
# Separate-Port Burst SRAM Controller

This controller connects a simple request interface to a synchronous SRAM whose read data and write data travel on separate one-way buses. Users post read requests (a burst address) and write requests (a burst address, four data words and a per-byte write mask) through valid/ready handshakes. Read data returns later as two word pairs, each marked with a valid strobe.

On the memory side, a single address bus is time-shared inside each clock period. The first half of the period carries the read address and the second half carries the write address. This is modelled as two address fields, one per half-period. Each port has its own active-low select. A burst is four sequential words. Each port moves one word per clock edge, so every data exchange appears as a rise/fall word pair on each clock. A burst therefore takes two clocks on each port, and no turnaround gap is ever needed between reads and writes. Each port accepts a new command at most every second cycle. The read return delay is a parameter.

Top module: `sram_burst_ctrl`

## Requirements
- R1: While reset is held, both memory selects are high, the read response strobe is low, and both request ready outputs are high.
- R2: A read accepted at a clock edge drives `mem_rps_n` low in the next cycle, for exactly one cycle, with the request address on `mem_addr_rph`.
- R3: A write accepted at a clock edge drives `mem_wps_n` low in the next cycle, for exactly one cycle, with the request address on `mem_addr_wph`.
- R4: Each port's ready output is low in the cycle after an acceptance on that port and high again in the cycle after that. Each port therefore issues at most one burst per two cycles.
- R5: Word i of a write is taken from `wr_req_data[i*WORD_W +: WORD_W]`. Words 0 and 1 appear on `mem_wd_rise`/`mem_wd_fall` in the first cycle after the write-address cycle, and words 2 and 3 in the second cycle. Alongside each word, its byte enables are the inverse of the mask bits `wr_req_mask[i*NBYTES +: NBYTES]`, where mask bit b covers data bits `[b*BYTE_W +: BYTE_W]` of that word.
- R6: Outside the two data cycles that follow each write-address cycle, all byte enables are high.
- R7: A write whose mask is all zeros still drives the write select and both data cycles, with every byte enable high, so no stored byte changes.
- R8: Read data is sampled from `mem_rd_rise`/`mem_rd_fall` RD_LAT and RD_LAT+1 cycles after the read-address cycle. It is delivered one cycle after each sample with `rd_resp_valid` high. `rd_resp_beat` is 0 for words 0/1 and 1 for words 2/3.
- R9: A read and a write accepted at the same edge are issued in the same cycle, each on its own half of the address bus, and both complete without interfering.
- R10: A write with a partial mask changes only the enabled bytes. A later read returns the merged contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request can be accepted |
| rd_req_addr | input | ADDR_W | Read burst address |
| rd_resp_valid | output | 1 | Returned word pair valid |
| rd_resp_beat | output | 1 | 0: words 0/1, 1: words 2/3 |
| rd_resp_rise | output | WORD_W | Even word of the pair |
| rd_resp_fall | output | WORD_W | Odd word of the pair |
| wr_req_valid | input | 1 | Write request valid |
| wr_req_ready | output | 1 | Write request can be accepted |
| wr_req_addr | input | ADDR_W | Write burst address |
| wr_req_data | input | 4*WORD_W | Four burst words, word 0 lowest |
| wr_req_mask | input | 4*WORD_W/BYTE_W | Byte write mask, 1 = write |
| mem_addr_rph | output | ADDR_W | Address bus, read half-period |
| mem_addr_wph | output | ADDR_W | Address bus, write half-period |
| mem_rps_n | output | 1 | Read port select, active low |
| mem_wps_n | output | 1 | Write port select, active low |
| mem_wd_rise | output | WORD_W | Write word on rising edge |
| mem_wd_fall | output | WORD_W | Write word on falling edge |
| mem_bwe_rise_n | output | WORD_W/BYTE_W | Byte enables for the rising word, active low |
| mem_bwe_fall_n | output | WORD_W/BYTE_W | Byte enables for the falling word, active low |
| mem_rd_rise | input | WORD_W | Read word from the rising edge |
| mem_rd_fall | input | WORD_W | Read word from the falling edge |

## Verification
The properties assume that the memory returns each read burst exactly RD_LAT cycles after the address, and that users hold no assumptions about ready other than the handshake itself. The pairing property for responses also relies on read bursts never being issued closer together than two cycles, which the controller itself enforces. The bench's memory model answers with exactly the configured delay. Concurrent traffic only targets disjoint addresses, so the order in which stores are committed is never ambiguous. Overlapping addresses are exercised only in sequential phases, after earlier writes have fully drained.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   localparam int unsigned BURST_WORDS = 4;
   localparam int unsigned PAIRS       = BURST_WORDS / 2;
endpackage

// File: rtl/sbc_wr_seq.sv
module sbc_wr_seq
   import sbc_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned WORD_W = 36,
   parameter int unsigned NBYTES = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [BURST_WORDS*WORD_W-1:0] req_data,
   input  logic [BURST_WORDS*NBYTES-1:0] req_mask,
   output logic                          wps_n,
   output logic [ADDR_W-1:0]             addr,
   output logic [WORD_W-1:0]             wd_rise,
   output logic [WORD_W-1:0]             wd_fall,
   output logic [NBYTES-1:0]             bwe_rise_n,
   output logic [NBYTES-1:0]             bwe_fall_n
);
   localparam int unsigned DW = BURST_WORDS * WORD_W;
   localparam int unsigned MW = BURST_WORDS * NBYTES;

   logic [DW-1:0]     data_q;
   logic [MW-1:0]     mask_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wps_n_q;
   logic              second_q;
   logic              fire;
   logic [WORD_W-1:0] word  [BURST_WORDS];
   logic [NBYTES-1:0] wmask [BURST_WORDS];

   generate
      for (genvar i = 0; i < BURST_WORDS; i++) begin : g_unpack
         assign word[i]  = data_q[i*WORD_W +: WORD_W];
         assign wmask[i] = mask_q[i*NBYTES +: NBYTES];
      end
   endgenerate

   assign req_ready = wps_n_q;
   assign fire      = req_valid & req_ready;
   assign wps_n     = wps_n_q;
   assign addr      = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wps_n_q    <= 1'b1;
         second_q   <= 1'b0;
         addr_q     <= '0;
         data_q     <= '0;
         mask_q     <= '0;
         wd_rise    <= '0;
         wd_fall    <= '0;
         bwe_rise_n <= '1;
         bwe_fall_n <= '1;
      end else begin
         wps_n_q  <= ~fire;
         second_q <= ~wps_n_q;
         if (fire) begin
            addr_q <= req_addr;
            data_q <= req_data;
            mask_q <= req_mask;
         end
         if (!wps_n_q) begin
            wd_rise    <= word[0];
            wd_fall    <= word[1];
            bwe_rise_n <= ~wmask[0];
            bwe_fall_n <= ~wmask[1];
         end else if (second_q) begin
            wd_rise    <= word[2];
            wd_fall    <= word[3];
            bwe_rise_n <= ~wmask[2];
            bwe_fall_n <= ~wmask[3];
         end else begin
            bwe_rise_n <= '1;
            bwe_fall_n <= '1;
         end
      end
   end
endmodule

// File: rtl/sbc_rd_seq.sv
module sbc_rd_seq #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned WORD_W = 36,
   parameter int unsigned RD_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rps_n,
   output logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] rd_rise,
   input  logic [WORD_W-1:0] rd_fall,
   output logic              resp_valid,
   output logic              resp_beat,
   output logic [WORD_W-1:0] resp_rise,
   output logic [WORD_W-1:0] resp_fall
);
   localparam int unsigned PW = RD_LAT + 1;

   logic              rps_n_q;
   logic [ADDR_W-1:0] addr_q;
   logic [PW-1:0]     pend;
   logic              fire;
   logic              take0;
   logic              take1;

   assign req_ready = rps_n_q;
   assign fire      = req_valid & req_ready;
   assign rps_n     = rps_n_q;
   assign addr      = addr_q;
   assign take0     = pend[RD_LAT-1];
   assign take1     = pend[RD_LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rps_n_q    <= 1'b1;
         addr_q     <= '0;
         pend       <= '0;
         resp_valid <= 1'b0;
         resp_beat  <= 1'b0;
         resp_rise  <= '0;
         resp_fall  <= '0;
      end else begin
         rps_n_q    <= ~fire;
         if (fire) addr_q <= req_addr;
         pend       <= {pend[RD_LAT-1:0], ~rps_n_q};
         resp_valid <= take0 | take1;
         resp_beat  <= take1;
         if (take0 | take1) begin
            resp_rise <= rd_rise;
            resp_fall <= rd_fall;
         end
      end
   end
endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
   import sbc_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned WORD_W = 36,
   parameter int unsigned BYTE_W = 9,
   parameter int unsigned RD_LAT = 2,
   localparam int unsigned NBYTES = WORD_W / BYTE_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rd_req_valid,
   output logic                          rd_req_ready,
   input  logic [ADDR_W-1:0]             rd_req_addr,
   output logic                          rd_resp_valid,
   output logic                          rd_resp_beat,
   output logic [WORD_W-1:0]             rd_resp_rise,
   output logic [WORD_W-1:0]             rd_resp_fall,
   input  logic                          wr_req_valid,
   output logic                          wr_req_ready,
   input  logic [ADDR_W-1:0]             wr_req_addr,
   input  logic [BURST_WORDS*WORD_W-1:0] wr_req_data,
   input  logic [BURST_WORDS*NBYTES-1:0] wr_req_mask,
   output logic [ADDR_W-1:0]             mem_addr_rph,
   output logic [ADDR_W-1:0]             mem_addr_wph,
   output logic                          mem_rps_n,
   output logic                          mem_wps_n,
   output logic [WORD_W-1:0]             mem_wd_rise,
   output logic [WORD_W-1:0]             mem_wd_fall,
   output logic [NBYTES-1:0]             mem_bwe_rise_n,
   output logic [NBYTES-1:0]             mem_bwe_fall_n,
   input  logic [WORD_W-1:0]             mem_rd_rise,
   input  logic [WORD_W-1:0]             mem_rd_fall
);
   generate
      if (RD_LAT < 1) begin : g_bad_latency
         $error("RD_LAT must be at least 1");
      end
      if ((WORD_W % BYTE_W) != 0 || NBYTES < 1) begin : g_bad_bytes
         $error("WORD_W must be a whole multiple of BYTE_W");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   sbc_rd_seq #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W),
      .RD_LAT (RD_LAT)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (rd_req_valid),
      .req_ready  (rd_req_ready),
      .req_addr   (rd_req_addr),
      .rps_n      (mem_rps_n),
      .addr       (mem_addr_rph),
      .rd_rise    (mem_rd_rise),
      .rd_fall    (mem_rd_fall),
      .resp_valid (rd_resp_valid),
      .resp_beat  (rd_resp_beat),
      .resp_rise  (rd_resp_rise),
      .resp_fall  (rd_resp_fall)
   );

   sbc_wr_seq #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W),
      .NBYTES (NBYTES)
   ) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (wr_req_valid),
      .req_ready  (wr_req_ready),
      .req_addr   (wr_req_addr),
      .req_data   (wr_req_data),
      .req_mask   (wr_req_mask),
      .wps_n      (mem_wps_n),
      .addr       (mem_addr_wph),
      .wd_rise    (mem_wd_rise),
      .wd_fall    (mem_wd_fall),
      .bwe_rise_n (mem_bwe_rise_n),
      .bwe_fall_n (mem_bwe_fall_n)
   );
endmodule

// File: rtl/sram_burst_ctrl_chk.sv
module sram_burst_ctrl_chk #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned NBYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req_valid,
   input logic              rd_req_ready,
   input logic [ADDR_W-1:0] rd_req_addr,
   input logic              wr_req_valid,
   input logic              wr_req_ready,
   input logic [ADDR_W-1:0] wr_req_addr,
   input logic              rd_resp_valid,
   input logic              rd_resp_beat,
   input logic [ADDR_W-1:0] mem_addr_rph,
   input logic [ADDR_W-1:0] mem_addr_wph,
   input logic              mem_rps_n,
   input logic              mem_wps_n,
   input logic [NBYTES-1:0] mem_bwe_rise_n,
   input logic [NBYTES-1:0] mem_bwe_fall_n
);
   p_rd_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && rd_req_ready) |=> (!mem_rps_n && mem_addr_rph == $past(rd_req_addr)));

   p_wr_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_valid && wr_req_ready) |=> (!mem_wps_n && mem_addr_wph == $past(wr_req_addr)));

   p_rd_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rps_n |=> mem_rps_n);

   p_wr_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wps_n |=> mem_wps_n);

   p_bwe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem_wps_n) && $past(mem_wps_n, 2)) |-> (&mem_bwe_rise_n && &mem_bwe_fall_n));

   p_resp_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_resp_valid && !rd_resp_beat) |=> (rd_resp_valid && rd_resp_beat));
endmodule

bind sram_burst_ctrl sram_burst_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .NBYTES (NBYTES)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rd_req_valid   (rd_req_valid),
   .rd_req_ready   (rd_req_ready),
   .rd_req_addr    (rd_req_addr),
   .wr_req_valid   (wr_req_valid),
   .wr_req_ready   (wr_req_ready),
   .wr_req_addr    (wr_req_addr),
   .rd_resp_valid  (rd_resp_valid),
   .rd_resp_beat   (rd_resp_beat),
   .mem_addr_rph   (mem_addr_rph),
   .mem_addr_wph   (mem_addr_wph),
   .mem_rps_n      (mem_rps_n),
   .mem_wps_n      (mem_wps_n),
   .mem_bwe_rise_n (mem_bwe_rise_n),
   .mem_bwe_fall_n (mem_bwe_fall_n)
);

// File: tb/sram_burst_ctrl_test.sv
module sram_burst_ctrl_test;
   localparam int AW  = 4;
   localparam int WW  = 16;
   localparam int BW  = 8;
   localparam int NB  = 2;
   localparam int LAT = 3;
   localparam int NA  = 1 << AW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          rd_req_valid = 1'b0, wr_req_valid = 1'b0;
   logic          rd_req_ready, wr_req_ready;
   logic [AW-1:0] rd_req_addr = '0, wr_req_addr = '0;
   logic          rd_resp_valid, rd_resp_beat;
   logic [WW-1:0] rd_resp_rise, rd_resp_fall;
   logic [63:0]   wr_req_data = '0;
   logic [7:0]    wr_req_mask = '0;
   logic [AW-1:0] mem_addr_rph, mem_addr_wph;
   logic          mem_rps_n, mem_wps_n;
   logic [WW-1:0] mem_wd_rise, mem_wd_fall;
   logic [NB-1:0] mem_bwe_rise_n, mem_bwe_fall_n;
   logic [WW-1:0] mem_rd_rise = '0, mem_rd_fall = '0;

   sram_burst_ctrl #(.ADDR_W(AW), .WORD_W(WW), .BYTE_W(BW), .RD_LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
      .rd_resp_valid(rd_resp_valid), .rd_resp_beat(rd_resp_beat),
      .rd_resp_rise(rd_resp_rise), .rd_resp_fall(rd_resp_fall),
      .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
      .wr_req_data(wr_req_data), .wr_req_mask(wr_req_mask),
      .mem_addr_rph(mem_addr_rph), .mem_addr_wph(mem_addr_wph),
      .mem_rps_n(mem_rps_n), .mem_wps_n(mem_wps_n),
      .mem_wd_rise(mem_wd_rise), .mem_wd_fall(mem_wd_fall),
      .mem_bwe_rise_n(mem_bwe_rise_n), .mem_bwe_fall_n(mem_bwe_fall_n),
      .mem_rd_rise(mem_rd_rise), .mem_rd_fall(mem_rd_fall)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, fails = 0;
   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [15:0] pat(int a, int w, int s);
      return 16'((a * 613 + w * 97 + s * 4099 + 7) ^ (s << 12));
   endfunction
   function automatic logic [63:0] burst(int a, int s);
      return {pat(a, 3, s), pat(a, 2, s), pat(a, 1, s), pat(a, 0, s)};
   endfunction

   // reference contents, updated in issue order
   logic [WW-1:0] ref_mem [NA][4];
   // behavioural memory
   logic [WW-1:0] mdl [NA][4];
   logic [WW-1:0] rh_d [8][4];
   bit            rh_v [8];
   int            wst = 0;
   int            waddr = 0;
   // response expectations
   logic [WW-1:0] exp_w [64][4];
   int            exp_cyc [64];
   string         exp_tag [64];
   int            head = 0, tail = 0, mbeat = 0;
   int            r6_bad = 0, both_low = 0;
   bit            pw1 = 1'b1, pw2 = 1'b1;

   initial begin
      for (int a = 0; a < NA; a++)
         for (int w = 0; w < 4; w++) begin
            ref_mem[a][w] = '0;
            mdl[a][w] = '0;
         end
      for (int s = 0; s < 8; s++) rh_v[s] = 1'b0;
   end

   task automatic mdl_put(int a, int w, logic [WW-1:0] d, logic [NB-1:0] be_n);
      for (int b = 0; b < NB; b++)
         if (!be_n[b]) mdl[a][w][b*BW +: BW] = d[b*BW +: BW];
   endtask

   // memory model and port monitors
   always @(negedge clk) begin
      if (rst_n) begin
         if (wst == 1) begin
            mdl_put(waddr, 0, mem_wd_rise, mem_bwe_rise_n);
            mdl_put(waddr, 1, mem_wd_fall, mem_bwe_fall_n);
            wst = 2;
         end else if (wst == 2) begin
            mdl_put(waddr, 2, mem_wd_rise, mem_bwe_rise_n);
            mdl_put(waddr, 3, mem_wd_fall, mem_bwe_fall_n);
            wst = 0;
         end
         if (!mem_wps_n) begin
            waddr = int'(mem_addr_wph);
            wst = 1;
         end
         rh_v[cyc % 8] = !mem_rps_n;
         if (!mem_rps_n)
            for (int w = 0; w < 4; w++) rh_d[cyc % 8][w] = mdl[mem_addr_rph][w];
         mem_rd_rise = '0;
         mem_rd_fall = '0;
         if (cyc >= LAT && rh_v[(cyc - LAT) % 8]) begin
            mem_rd_rise = rh_d[(cyc - LAT) % 8][0];
            mem_rd_fall = rh_d[(cyc - LAT) % 8][1];
         end else if (cyc >= LAT + 1 && rh_v[(cyc - LAT - 1) % 8]) begin
            mem_rd_rise = rh_d[(cyc - LAT - 1) % 8][2];
            mem_rd_fall = rh_d[(cyc - LAT - 1) % 8][3];
         end
         // R6: byte enables idle outside write data cycles
         if (pw1 && pw2 && !(&mem_bwe_rise_n && &mem_bwe_fall_n)) r6_bad++;
         pw2 = pw1;
         pw1 = mem_wps_n;
         // R9: both ports issued in one cycle
         if (!mem_rps_n && !mem_wps_n) both_low++;
         // R8: response timing, order and data
         if (rd_resp_valid) begin
            if (head == tail) begin
               chk(1'b0, "R8 unexpected response", 64'(rd_resp_rise), 64'(0));
            end else begin
               chk(cyc == exp_cyc[head % 64] + mbeat && rd_resp_beat == mbeat[0],
                   {exp_tag[head % 64], " timing"},
                   64'({cyc, 31'd0, rd_resp_beat}),
                   64'({exp_cyc[head % 64] + mbeat, 31'd0, mbeat[0]}));
               chk({rd_resp_rise, rd_resp_fall} ==
                   {exp_w[head % 64][2*mbeat], exp_w[head % 64][2*mbeat+1]},
                   {exp_tag[head % 64], " data"},
                   64'({rd_resp_rise, rd_resp_fall}),
                   64'({exp_w[head % 64][2*mbeat], exp_w[head % 64][2*mbeat+1]}));
               if (mbeat == 1) begin
                  head++;
                  mbeat = 0;
               end else begin
                  mbeat = 1;
               end
            end
         end
      end
   end

   task automatic do_read(int a, string tg);
      int t;
      @(negedge clk);
      while (!rd_req_ready) @(negedge clk);
      rd_req_valid = 1'b1;
      rd_req_addr  = AW'(a);
      t = cyc;
      for (int w = 0; w < 4; w++) exp_w[tail % 64][w] = ref_mem[a][w];
      exp_cyc[tail % 64] = t + LAT + 2;
      exp_tag[tail % 64] = tg;
      tail++;
      @(negedge clk);
      rd_req_valid = 1'b0;
      chk(!mem_rps_n && mem_addr_rph == AW'(a), "R2 read issue",
          64'({mem_rps_n, mem_addr_rph}), 64'({1'b0, AW'(a)}));
      chk(!rd_req_ready, "R4 read ready low", 64'(rd_req_ready), 64'(0));
   endtask

   task automatic do_write(int a, logic [63:0] d, logic [7:0] m, string tg);
      @(negedge clk);
      while (!wr_req_ready) @(negedge clk);
      wr_req_valid = 1'b1;
      wr_req_addr  = AW'(a);
      wr_req_data  = d;
      wr_req_mask  = m;
      for (int w = 0; w < 4; w++)
         for (int b = 0; b < NB; b++)
            if (m[w*NB + b]) ref_mem[a][w][b*BW +: BW] = d[w*WW + b*BW +: BW];
      @(negedge clk);
      wr_req_valid = 1'b0;
      chk(!mem_wps_n && mem_addr_wph == AW'(a), "R3 write issue",
          64'({mem_wps_n, mem_addr_wph}), 64'({1'b0, AW'(a)}));
      chk(!wr_req_ready, "R4 write ready low", 64'(wr_req_ready), 64'(0));
      @(negedge clk);
      chk({mem_wd_rise, mem_wd_fall, mem_bwe_rise_n, mem_bwe_fall_n} ==
          {d[15:0], d[31:16], ~m[1:0], ~m[3:2]}, {tg, " write pair 0"},
          64'({mem_wd_rise, mem_wd_fall, mem_bwe_rise_n, mem_bwe_fall_n}),
          64'({d[15:0], d[31:16], ~m[1:0], ~m[3:2]}));
      chk(wr_req_ready, "R4 write ready back", 64'(wr_req_ready), 64'(1));
      @(negedge clk);
      chk({mem_wd_rise, mem_wd_fall, mem_bwe_rise_n, mem_bwe_fall_n} ==
          {d[47:32], d[63:48], ~m[5:4], ~m[7:6]}, {tg, " write pair 1"},
          64'({mem_wd_rise, mem_wd_fall, mem_bwe_rise_n, mem_bwe_fall_n}),
          64'({d[47:32], d[63:48], ~m[5:4], ~m[7:6]}));
   endtask

   task automatic gap(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      gap(3);
      // R1: reset state
      chk(mem_rps_n && mem_wps_n, "R1 selects", 64'({mem_rps_n, mem_wps_n}), 64'(3));
      chk(!rd_resp_valid, "R1 resp idle", 64'(rd_resp_valid), 64'(0));
      chk(rd_req_ready && wr_req_ready, "R1 ready", 64'({rd_req_ready, wr_req_ready}), 64'(3));
      rst_n = 1'b1;
      gap(2);

      for (int a = 0; a < NA; a++) do_write(a, burst(a, 1), 8'hFF, "R5");
      gap(2);
      for (int a = 0; a < NA; a++) do_read(a, "R8");
      gap(12);

      // R9: concurrent read and write on disjoint addresses
      for (int i = 0; i < NA / 2; i++) begin
         fork
            do_read(i, "R9");
            do_write(i + NA / 2, burst(i + NA / 2, 2), 8'hFF, "R9");
         join
      end
      gap(12);
      for (int a = 0; a < NA; a++) do_read(a, "R9");
      gap(12);

      // R10 partial mask, R7 zero mask
      do_write(3, burst(3, 3), 8'h65, "R10");
      do_write(5, burst(5, 4), 8'h00, "R7");
      do_write(6, burst(6, 5), 8'h9A, "R10");
      gap(2);
      do_read(3, "R10");
      do_read(5, "R7");
      do_read(6, "R10");
      gap(14);

      chk(head == tail, "R8 all bursts returned", 64'(head), 64'(tail));
      chk(r6_bad == 0, "R6 idle byte enables", 64'(r6_bad), 64'(0));
      chk(both_low == NA / 2, "R9 same-cycle issue", 64'(both_low), 64'(NA / 2));
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule